// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block evaluates one of sixteen floating-point compare predicates on two operands and keeps the outcome as a condition bit. It works in single or double precision. Each predicate is a set of relations: unordered, equal and less-than. The condition is true when any selected relation holds between the operands. A fourth code bit marks the predicate as signaling, which makes the unit stricter about NaN inputs when it reports an invalid operation.

The condition bit and the invalid-operation status live in a small slice of a control/status word. The condition sits at bit 23, the invalid cause at bit 17, the invalid enable at bit 11 and the sticky invalid flag at bit 6. A write to that word loads these four bits. Branch logic asks whether a branch-on-true or branch-on-false would be taken, and the unit answers from the condition bit it holds at that moment.

Top module: `fcmp_cond_unit`

## Requirements
- R1: While reset is asserted and right after it is released, condBit, invCause, invFlag, excReq and brTaken are all 0.
- R2: The condition bit changes only on a clock edge where cmpValid (or csrWe) is high, so a compare result becomes visible one cycle after its strobe. With neither strobe high, condBit holds its value whatever the operand inputs do.
- R3: predCode bit0 selects unordered, bit1 selects equal, bit2 selects less-than (a < b), and bit3 marks a signaling predicate. The result is the OR of the selected relations. Codes 0 and 8 always give false. Codes 1 and 9 give true exactly when either operand is NaN.
- R4: When either operand is NaN, the equal and less-than relations are false, so the result equals predCode bit0.
- R5: For non-NaN operands, equal and less-than follow numeric order. This holds across signs, subnormals and both infinities.
- R6: Positive zero and negative zero compare as equal and not less-than, in either order.
- R7: With isDouble = 0, operands are single precision and are taken from bits 31:0 only. Bits 63:32 have no effect on the result.
- R8: On each compare, invCause is set to the invalid outcome of that compare. A signaling predicate is invalid when either operand is any NaN. A non-signaling predicate is invalid only when an operand is a signaling NaN, meaning a NaN whose top fraction bit is 0. invCause holds between compares.
- R9: invFlag is set by any invalid compare and stays set across later compares. Only a control write clears it.
- R10: excReq is high exactly when invCause and the invalid enable bit are both 1.
- R11: brTaken = brReq and (condBit equals brOnTrue). It is combinational on the held condition bit and is 0 when brReq is 0.
- R12: When csrWe is high, the next edge loads condBit from csrWdata bit 23, invCause from bit 17, the enable from bit 11 and invFlag from bit 6. In the same cycle a write takes priority over a compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 64 | First operand (single uses bits 31:0) |
| opB | input | 64 | Second operand (single uses bits 31:0) |
| isDouble | input | 1 | 1 selects double precision, 0 selects single |
| predCode | input | 4 | Predicate code: bit0 unordered, bit1 equal, bit2 less, bit3 signaling |
| cmpValid | input | 1 | Compare strobe |
| csrWe | input | 1 | Control/status word write strobe |
| csrWdata | input | 32 | Control/status write data |
| brReq | input | 1 | Branch test request |
| brOnTrue | input | 1 | 1 tests branch-on-true, 0 tests branch-on-false |
| condBit | output | 1 | Held compare condition |
| invCause | output | 1 | Invalid cause of the most recent compare |
| invFlag | output | 1 | Sticky invalid flag |
| excReq | output | 1 | Exception request (cause and enable) |
| brTaken | output | 1 | Branch decision |

## Verification
The condition, cause, flag and exception request come from registers. Each is due at the first clock edge after the strobe that produced it. The bench drives each strobe on a falling edge and samples on the next falling edge. It also samples once just after driving, to confirm that the old value has not yet moved. brTaken is combinational on the held condition, so it is probed a nanosecond after its request changes, inside the same half cycle and before the next rising edge.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int DATA_W     = 64;
  localparam int SGL_W      = 32;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int MAG_W      = DATA_W - 1;
  localparam int CODE_W     = 4;
  localparam int CSR_W      = 32;
  localparam int COND_BIT   = 23;
  localparam int CAUSE_BIT  = 17;
  localparam int ENA_BIT    = 11;
  localparam int FLAG_BIT   = 6;

  typedef struct packed {
    logic useUn;
    logic useEq;
    logic useLt;
    logic signalAll;
  } cmpStrobe_t;

  typedef struct packed {
    logic result;
    logic invalid;
  } cmpResult_t;
endpackage

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              isDouble,
  input  cmpStrobe_t        strobe,
  output cmpResult_t        res
);
  logic [DATA_W-1:0] opArr [2];
  logic [MAG_W-1:0]  mag   [2];
  logic [1:0] sgn, nan, sNan, zero;

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    logic [DBL_EXP_W-1:0]  dExp;
    logic [DBL_FRAC_W-1:0] dFrac;
    logic [SGL_EXP_W-1:0]  sExp;
    logic [SGL_FRAC_W-1:0] sFrac;
    logic                  lSgn, lNan, lQuiet;
    logic [MAG_W-1:0]      lMag;

    assign dExp  = opArr[k][DATA_W-2 -: DBL_EXP_W];
    assign dFrac = opArr[k][DBL_FRAC_W-1:0];
    assign sExp  = opArr[k][SGL_W-2 -: SGL_EXP_W];
    assign sFrac = opArr[k][SGL_FRAC_W-1:0];

    always_comb begin
      if (isDouble) begin
        lSgn   = opArr[k][DATA_W-1];
        lMag   = opArr[k][MAG_W-1:0];
        lNan   = (&dExp) && (|dFrac);
        lQuiet = dFrac[DBL_FRAC_W-1];
      end else begin
        lSgn   = opArr[k][SGL_W-1];
        lMag   = {{(MAG_W-SGL_W+1){1'b0}}, opArr[k][SGL_W-2:0]};
        lNan   = (&sExp) && (|sFrac);
        lQuiet = sFrac[SGL_FRAC_W-1];
      end
    end

    assign sgn[k]  = lSgn;
    assign mag[k]  = lMag;
    assign nan[k]  = lNan;
    assign sNan[k] = lNan && !lQuiet;
    assign zero[k] = (lMag == '0);
  end

  logic unord, equal, less, rawLess;

  always_comb begin
    unord = |nan;
    equal = !unord && ((&zero) || (sgn[0] == sgn[1] && mag[0] == mag[1]));
    unique case ({sgn[0], sgn[1]})
      2'b10:   rawLess = 1'b1;
      2'b01:   rawLess = 1'b0;
      2'b00:   rawLess = mag[0] < mag[1];
      default: rawLess = mag[0] > mag[1];
    endcase
    less = rawLess && !unord && !equal;
    res.result  = (strobe.useUn && unord) || (strobe.useEq && equal) ||
                  (strobe.useLt && less);
    res.invalid = strobe.signalAll ? unord : |sNan;
  end
endmodule

// File: rtl/fcmp_control.sv
module fcmp_control
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] predCode,
  input  logic              cmpValid,
  input  logic              csrWe,
  input  logic [CSR_W-1:0]  csrWdata,
  input  logic              brReq,
  input  logic              brOnTrue,
  input  cmpResult_t        res,
  output cmpStrobe_t        strobe,
  output logic              condBit,
  output logic              invCause,
  output logic              invFlag,
  output logic              excReq,
  output logic              brTaken
);
  logic condQ, causeQ, enaQ, flagQ;
  logic unusedCsrBits;

  assign unusedCsrBits = ^{csrWdata[CSR_W-1:COND_BIT+1], csrWdata[COND_BIT-1:CAUSE_BIT+1],
                           csrWdata[CAUSE_BIT-1:ENA_BIT+1], csrWdata[ENA_BIT-1:FLAG_BIT+1],
                           csrWdata[FLAG_BIT-1:0]};

  assign strobe = '{useUn: predCode[0], useEq: predCode[1],
                    useLt: predCode[2], signalAll: predCode[3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      condQ  <= 1'b0;
      causeQ <= 1'b0;
      enaQ   <= 1'b0;
      flagQ  <= 1'b0;
    end else if (csrWe) begin
      condQ  <= csrWdata[COND_BIT];
      causeQ <= csrWdata[CAUSE_BIT];
      enaQ   <= csrWdata[ENA_BIT];
      flagQ  <= csrWdata[FLAG_BIT];
    end else if (cmpValid) begin
      condQ  <= res.result;
      causeQ <= res.invalid;
      flagQ  <= flagQ | res.invalid;
    end
  end

  assign condBit  = condQ;
  assign invCause = causeQ;
  assign invFlag  = flagQ;
  assign excReq   = causeQ & enaQ;
  assign brTaken  = brReq & (condQ == brOnTrue);
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              isDouble,
  input  logic [CODE_W-1:0] predCode,
  input  logic              cmpValid,
  input  logic              csrWe,
  input  logic [CSR_W-1:0]  csrWdata,
  input  logic              brReq,
  input  logic              brOnTrue,
  output logic              condBit,
  output logic              invCause,
  output logic              invFlag,
  output logic              excReq,
  output logic              brTaken
);
  cmpStrobe_t strobe;
  cmpResult_t res;

  fcmp_datapath u_dp (
    .opA(opA), .opB(opB), .isDouble(isDouble), .strobe(strobe), .res(res)
  );

  fcmp_control u_ctl (
    .clk(clk), .rstN(rstN), .predCode(predCode), .cmpValid(cmpValid),
    .csrWe(csrWe), .csrWdata(csrWdata), .brReq(brReq), .brOnTrue(brOnTrue),
    .res(res), .strobe(strobe), .condBit(condBit), .invCause(invCause),
    .invFlag(invFlag), .excReq(excReq), .brTaken(brTaken)
  );
endmodule

// File: rtl/fcmp_cond_checker.sv
module fcmp_cond_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmpValid,
  input logic       csrWe,
  input logic [2:0] predLow,
  input logic       wrCond,
  input logic       wrFlag,
  input logic       brReq,
  input logic       condBit,
  input logic       invCause,
  input logic       invFlag,
  input logic       excReq,
  input logic       brTaken
);
  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid && !csrWe |=> $stable(condBit)); // R2
  AST_FALSE_PRED: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && !csrWe && predLow == 3'b000 |=> !condBit); // R3
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmpValid && !csrWe |=> $stable(invCause)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    invFlag && !csrWe |=> invFlag); // R9
  AST_CAUSE_TO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid && !csrWe |=> !invCause || invFlag); // R9
  AST_EXC_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> invCause); // R10
  AST_BRANCH_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !brReq |-> !brTaken); // R11
  AST_CSR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    csrWe |=> condBit == $past(wrCond) && invFlag == $past(wrFlag)); // R12
endmodule

bind fcmp_cond_unit fcmp_cond_checker u_chk (
  .clk(clk), .rstN(rstN), .cmpValid(cmpValid), .csrWe(csrWe),
  .predLow(predCode[2:0]), .wrCond(csrWdata[fcmp_pkg::COND_BIT]),
  .wrFlag(csrWdata[fcmp_pkg::FLAG_BIT]), .brReq(brReq), .condBit(condBit),
  .invCause(invCause), .invFlag(invFlag), .excReq(excReq), .brTaken(brTaken)
);

// File: tb/fcmp_cond_unit_tb.sv
`timescale 1ns/1ps
module fcmp_cond_unit_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] opA, opB;
  logic        isDouble;
  logic [3:0]  predCode;
  logic        cmpValid, csrWe;
  logic [31:0] csrWdata;
  logic        brReq, brOnTrue;
  logic        condBit, invCause, invFlag, excReq, brTaken;

  int total = 0;
  int failCnt = 0;
  bit summaryDone = 0;
  logic expFlag;

  always #5 clk = ~clk;

  fcmp_cond_unit u_dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .isDouble(isDouble),
    .predCode(predCode), .cmpValid(cmpValid), .csrWe(csrWe), .csrWdata(csrWdata),
    .brReq(brReq), .brOnTrue(brOnTrue), .condBit(condBit), .invCause(invCause),
    .invFlag(invFlag), .excReq(excReq), .brTaken(brTaken)
  );

  localparam int NVAL = 12;

  function automatic logic [31:0] sglEnc(int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h3FC0_0000;  5: return 32'hC000_0000;
      6: return 32'h0000_0001;  7: return 32'h7F80_0000;
      8: return 32'hFF80_0000;  9: return 32'h7FC0_0000;
      10: return 32'h7F80_0001; default: return 32'hFFC0_0001;
    endcase
  endfunction

  function automatic logic [63:0] dblEnc(int i);
    case (i)
      0: return 64'h0000_0000_0000_0000;  1: return 64'h8000_0000_0000_0000;
      2: return 64'h3FF0_0000_0000_0000;  3: return 64'hBFF0_0000_0000_0000;
      4: return 64'h3FF8_0000_0000_0000;  5: return 64'hC000_0000_0000_0000;
      6: return 64'h36A0_0000_0000_0000;  7: return 64'h7FF0_0000_0000_0000;
      8: return 64'hFFF0_0000_0000_0000;  9: return 64'h7FF8_0000_0000_0000;
      10: return 64'h7FF0_0000_0000_0001; default: return 64'hFFF8_0000_0000_0001;
    endcase
  endfunction

  function automatic bit isNan(int i);  return i >= 9;  endfunction
  function automatic bit isSNan(int i); return i == 10; endfunction

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("%0d/%0d checks passed", total - failCnt, total);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic doCompare(input int f, input int i, input int j, input logic [3:0] c,
                           input bit en);
    bit un, eq, lt, expCond, expInv;
    real ra, rb;
    string condReq;
    isDouble = f[0];
    if (f == 1) begin
      opA = dblEnc(i);
      opB = dblEnc(j);
    end else begin
      opA = {32'h7FF8_0000 | i, sglEnc(i)};
      opB = {32'hFFF0_0000 | j, sglEnc(j)};
    end
    predCode = c;
    cmpValid = 1'b1;
    @(negedge clk);
    cmpValid = 1'b0;
    un = isNan(i) || isNan(j);
    eq = 0; lt = 0;
    if (!un) begin
      ra = $bitstoreal(dblEnc(i));
      rb = $bitstoreal(dblEnc(j));
      eq = (ra == rb);
      lt = (ra < rb);
    end
    expCond = (c[0] && un) || (c[1] && eq) || (c[2] && lt);
    expInv  = c[3] ? un : (isSNan(i) || isSNan(j));
    expFlag = expFlag | expInv;
    if (c[2:0] == 3'b000 || c[2:0] == 3'b001) condReq = "R3";
    else if (un) condReq = "R4";
    else if (i <= 1 && j <= 1) condReq = "R6";
    else if (f == 0) condReq = "R7";
    else condReq = "R5";
    chk(condReq, condBit, expCond);
    chk("R8", invCause, expInv);
    chk("R9", invFlag, expFlag);
    chk("R10", excReq, expInv && en);
    brReq = 1'b1; brOnTrue = 1'b0; #1;
    chk("R11", brTaken, !expCond);
    brOnTrue = 1'b1; #1;
    chk("R11", brTaken, expCond);
    brReq = 1'b0; #1;
    chk("R11", brTaken, 1'b0);
  endtask

  task automatic csrWrite(input logic [31:0] d);
    csrWe = 1'b1;
    csrWdata = d;
    @(negedge clk);
    csrWe = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; opA = '0; opB = '0; isDouble = 1'b1; predCode = '0;
    cmpValid = 1'b0; csrWe = 1'b0; csrWdata = '0; brReq = 1'b0; brOnTrue = 1'b0;
    expFlag = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", condBit, 1'b0);
    chk("R1", invCause, 1'b0);
    chk("R1", invFlag, 1'b0);
    chk("R1", excReq, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", condBit, 1'b0);
    brReq = 1'b1; brOnTrue = 1'b1; #1;
    chk("R1", brTaken, 1'b0);
    brReq = 1'b0;
    @(negedge clk);

    // R12: write wins over a simultaneous always-false compare
    predCode = 4'd0; cmpValid = 1'b1;
    csrWrite(32'h0082_0840);
    cmpValid = 1'b0;
    chk("R12", condBit, 1'b1);
    chk("R12", invCause, 1'b1);
    chk("R12", invFlag, 1'b1);
    chk("R10", excReq, 1'b1);

    // R9: a clean compare keeps the sticky flag, clears the cause
    expFlag = 1'b1;
    doCompare(1, 2, 2, 4'd2, 1'b1);
    chk("R9", invFlag, 1'b1);
    csrWrite(32'h0000_0000);
    chk("R9", invFlag, 1'b0);
    chk("R12", condBit, 1'b0);

    // R2: one-cycle latency and hold without a strobe
    isDouble = 1'b1; opA = dblEnc(2); opB = dblEnc(2); predCode = 4'd2; cmpValid = 1'b1;
    #1;
    chk("R2", condBit, 1'b0);
    @(negedge clk);
    cmpValid = 1'b0;
    chk("R2", condBit, 1'b1);
    opA = dblEnc(3);
    repeat (2) @(negedge clk);
    chk("R2", condBit, 1'b1);
    chk("R8", invCause, 1'b0);

    for (int f = 0; f < 2; f++) begin
      for (int e = 0; e < 2; e++) begin
        csrWrite(e == 1 ? 32'h0000_0800 : 32'h0000_0000);
        expFlag = 1'b0;
        for (int i = 0; i < NVAL; i++)
          for (int j = 0; j < NVAL; j++)
            for (int c = 0; c < 16; c++)
              doCompare(f, i, j, c[3:0], e[0]);
      end
    end

    summary();
    $finish;
  end

  initial begin
    #1_500_000;
    if (!summaryDone) begin
      total++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule